// File: doc/BRIEF.md
# Preemptive priority interrupt controller

This block sits between a set of interrupt sources and a single processor core. It combines a parameterised number of peripheral request lines with eight request bits that software can set and clear. Each source has a programmable priority from 0 to 15. Every cycle the block picks the most urgent pending source, and it raises one request to the core together with that source's vector number and priority. It raises the request only when that priority is strictly above the current priority.

When the core acknowledges, the block records the vector. It pushes the current priority onto a hardware LIFO and raises the current priority to the level of the taken source. A write to the end-of-interrupt address pops the LIFO and restores the level that was interrupted. Software may also write the current priority directly, for example to raise it to the ceiling of a shared resource. Background code runs at level 0.

The request output is driven by a two-state machine. ST_IDLE moves to ST_REQ when a pending source outranks the current priority. ST_REQ returns to ST_IDLE when the core acknowledges, or when no source outranks the current priority any more. ST_REQ also moves to ST_IDLE on an acknowledge, so the request is dropped for one cycle while the new current priority settles.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the current priority is 0, the request output is low, the error flag is 0, all priorities are 0 and no software bit is pending.
- R2: Software bit i (set by a write to address 0x03, cleared by a write to 0x04, both using one bit per source) is vector i. Peripheral line k is vector k+8. The priority of vector v is read and written at address 0x10+v, in bits 3:0.
- R3: The request output rises one clock after a pending source exists whose priority is strictly greater than the current priority. It then shows the highest such priority and its vector. A priority-0 source is never requested.
- R4: When several pending sources share the highest priority, the lowest vector number is presented, whatever the order in which they asserted.
- R5: An acknowledge pulse while the request is high sets the current priority to the presented priority and stores the vector, readable at address 0x01. It also drops the request for at least one cycle. An acknowledge while the request is low has no effect.
- R6: Acknowledging a software vector (0 to 7) clears its pending bit, as seen at address 0x03.
- R7: A write of any value to address 0x02 (end of interrupt) restores the current priority to its value before the most recent acknowledge. Restores happen in last-in first-out order.
- R8: An end of interrupt with nothing saved leaves the current priority unchanged and sets a sticky error flag (address 0x05, bit 0) that only reset clears.
- R9: The current priority is read and written at address 0x00, bits 3:0. A written level masks every source whose priority is at or below it.
- R10: The priority LIFO holds 16 entries. An acknowledge when it is full still takes the interrupt, but the save is discarded and the error flag is set.
- R11: An acknowledge has priority over a register write in the same cycle, and that write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| periph_req | input | NUM_PERIPH | Peripheral request lines, level sensitive |
| core_ack | input | 1 | One-cycle acknowledge pulse from the core |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 6 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| irq_req | output | 1 | Registered interrupt request to the core |
| irq_vector | output | VEC_W | Vector number of the presented source |
| irq_prio | output | 4 | Priority of the presented source |

## Verification
Each of the 16 vectors is tried alone at every priority level. This separates the vector mapping from the strict-greater rule and from the priority-0 exclusion. A single source is held fixed while the current priority sweeps all levels, which places the masking boundary exactly. Every pair of vectors at equal priority, and two full-population priority patterns (one without ties and one full of ties) under every current priority, separate lowest-vector tie-breaking from arrival order. A nested preempt-and-return sequence, an underfilled and an overfilled LIFO, and acknowledges with no request pending cover the save-and-restore path and its error cases.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
    localparam int NUM_SW   = 8;
    localparam int ADDR_W   = 6;
    localparam int DATA_W   = 8;

    localparam logic [ADDR_W-1:0] ADDR_CUR       = 6'h00;
    localparam logic [ADDR_W-1:0] ADDR_ACKVEC    = 6'h01;
    localparam logic [ADDR_W-1:0] ADDR_EOI       = 6'h02;
    localparam logic [ADDR_W-1:0] ADDR_SWSET     = 6'h03;
    localparam logic [ADDR_W-1:0] ADDR_SWCLR     = 6'h04;
    localparam logic [ADDR_W-1:0] ADDR_STAT      = 6'h05;
    localparam logic [ADDR_W-1:0] ADDR_PRIO_BASE = 6'h10;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_REQ  = 1'b1
    } req_state_e;
endpackage

// File: rtl/pic_arbiter.sv
`timescale 1ns/1ps
module pic_arbiter #(
    parameter int NVEC   = 16,
    parameter int PRIO_W = 4,
    parameter int VEC_W  = 4
) (
    input  logic [NVEC-1:0]        pending,
    input  logic [NVEC*PRIO_W-1:0] prio_flat,
    input  logic [PRIO_W-1:0]      cur_prio,
    output logic                   win_valid,
    output logic [VEC_W-1:0]       win_vec,
    output logic [PRIO_W-1:0]      win_prio
);
    // Scan from the top vector down; ">=" lets a lower vector displace an equal one.
    always_comb begin
        win_valid = 1'b0;
        win_vec   = '0;
        win_prio  = '0;
        for (int v = NVEC - 1; v >= 0; v--) begin
            if (pending[v] && (prio_flat[v*PRIO_W +: PRIO_W] > cur_prio)
                && (prio_flat[v*PRIO_W +: PRIO_W] >= win_prio)) begin
                win_valid = 1'b1;
                win_vec   = VEC_W'(v);
                win_prio  = prio_flat[v*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/pic_lifo.sv
`timescale 1ns/1ps
module pic_lifo #(
    parameter int DEPTH = 16,
    parameter int W     = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    logic [W-1:0]     mem [DEPTH];
    logic [CNT_W-1:0] cnt_q;

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign dout  = empty ? '0 : mem[IDX_W'(cnt_q - 1'b1)];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (push && !full) begin
            mem[IDX_W'(cnt_q)] <= din;
            cnt_q              <= cnt_q + 1'b1;
        end else if (pop && !empty) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R7: a successful pop removes exactly one saved level
    assert_pop_shrinks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !empty) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));
    // R10: a push that fits lands on top of the stack
    assert_push_on_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> (dout == $past(din)));
    // R10: a push onto a full stack is discarded
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> full && $stable(cnt_q));
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int NUM_PERIPH  = 8,
    parameter int PRIO_W      = 4,
    parameter int STACK_DEPTH = 16,
    localparam int NVEC  = NUM_PERIPH + NUM_SW,
    localparam int VEC_W = $clog2(NVEC)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PERIPH-1:0] periph_req,
    input  logic                  core_ack,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  irq_req,
    output logic [VEC_W-1:0]      irq_vector,
    output logic [PRIO_W-1:0]     irq_prio
);
    localparam int SW_IDX_W = $clog2(NUM_SW);

    req_state_e            state_q, state_d;
    logic [PRIO_W-1:0]     prio_q [NVEC];
    logic [NVEC*PRIO_W-1:0] prio_flat;
    logic [NUM_SW-1:0]     sw_pend_q;
    logic [PRIO_W-1:0]     cur_q;
    logic [VEC_W-1:0]      ackvec_q;
    logic                  err_q;
    logic [VEC_W-1:0]      vec_q;
    logic [PRIO_W-1:0]     pri_q;

    logic                  win_valid;
    logic [VEC_W-1:0]      win_vec;
    logic [PRIO_W-1:0]     win_prio;
    logic                  take, bus_wr, eoi;
    logic [PRIO_W-1:0]     stk_top;
    logic                  stk_empty, stk_full;

    for (genvar v = 0; v < NVEC; v++) begin : g_flat
        assign prio_flat[v*PRIO_W +: PRIO_W] = prio_q[v];
    end

    pic_arbiter #(.NVEC(NVEC), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_arb (
        .pending   ({periph_req, sw_pend_q}),
        .prio_flat (prio_flat),
        .cur_prio  (cur_q),
        .win_valid (win_valid),
        .win_vec   (win_vec),
        .win_prio  (win_prio)
    );

    assign take   = core_ack && (state_q == ST_REQ);
    assign bus_wr = wr_en && !take;
    assign eoi    = bus_wr && (wr_addr == ADDR_EOI);

    pic_lifo #(.DEPTH(STACK_DEPTH), .W(PRIO_W)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (take),
        .pop   (eoi),
        .din   (cur_q),
        .dout  (stk_top),
        .empty (stk_empty),
        .full  (stk_full)
    );

    // Next-state logic of the request machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (win_valid)           state_d = ST_REQ;
            ST_REQ:  if (take || !win_valid)  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs to the core
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
            pri_q <= '0;
        end else begin
            vec_q <= win_vec;
            pri_q <= win_prio;
        end
    end

    assign irq_req    = (state_q == ST_REQ);
    assign irq_vector = vec_q;
    assign irq_prio   = pri_q;

    // Programmer-visible state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q     <= '0;
            ackvec_q  <= '0;
            err_q     <= 1'b0;
            sw_pend_q <= '0;
            for (int v = 0; v < NVEC; v++) prio_q[v] <= '0;
        end else if (take) begin
            cur_q    <= pri_q;
            ackvec_q <= vec_q;
            if (stk_full) err_q <= 1'b1;
            if (vec_q < VEC_W'(NUM_SW)) sw_pend_q[SW_IDX_W'(vec_q)] <= 1'b0;
        end else if (bus_wr) begin
            if (wr_addr == ADDR_CUR)   cur_q     <= wr_data[PRIO_W-1:0];
            if (wr_addr == ADDR_SWSET) sw_pend_q <= sw_pend_q | wr_data[NUM_SW-1:0];
            if (wr_addr == ADDR_SWCLR) sw_pend_q <= sw_pend_q & ~wr_data[NUM_SW-1:0];
            if (eoi) begin
                if (stk_empty) err_q <= 1'b1;
                else           cur_q <= stk_top;
            end
            for (int v = 0; v < NVEC; v++)
                if (wr_addr == ADDR_W'(ADDR_PRIO_BASE + v)) prio_q[v] <= wr_data[PRIO_W-1:0];
        end
    end

    // Register read mux
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_CUR)    rd_data = DATA_W'(cur_q);
        if (rd_addr == ADDR_ACKVEC) rd_data = DATA_W'(ackvec_q);
        if (rd_addr == ADDR_SWSET)  rd_data = DATA_W'(sw_pend_q);
        if (rd_addr == ADDR_STAT)   rd_data = DATA_W'(err_q);
        for (int v = 0; v < NVEC; v++)
            if (rd_addr == ADDR_W'(ADDR_PRIO_BASE + v)) rd_data = DATA_W'(prio_q[v]);
    end

    // R3: a presented request always outranks the level it was judged against
    assert_req_above_cur_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_prio > $past(cur_q)));
    // R3: priority 0 is never presented
    assert_no_zero_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_prio != '0));
    // R5: acknowledge raises the current level to the presented one and drops the request
    assert_ack_raises_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (cur_q == $past(irq_prio)) && !irq_req);
    // R7: end of interrupt restores the saved level
    assert_eoi_restores_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !stk_empty) |=> (cur_q == $past(stk_top)));
    // R8: end of interrupt with nothing saved keeps the level and flags an error
    assert_eoi_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && stk_empty) |=> err_q && $stable(cur_q));
    // R8: the error flag is sticky
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
endmodule

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
    localparam int NP = 8;
    localparam int NV = NP + 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] periph_req = '0;
    logic          core_ack = 1'b0;
    logic          wr_en = 1'b0;
    logic [5:0]    wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [5:0]    rd_addr = '0;
    logic [7:0]    rd_data;
    logic          irq_req;
    logic [3:0]    irq_vector;
    logic [3:0]    irq_prio;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    prio_irq_ctrl #(.NUM_PERIPH(NP), .PRIO_W(4), .STACK_DEPTH(16)) uut (
        .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .core_ack(core_ack),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_req(irq_req), .irq_vector(irq_vector), .irq_prio(irq_prio)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a[5:0]; wr_data = d[7:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        rd_addr = a[5:0];
        #1;
        d = int'(rd_data);
    endtask

    task automatic ack();
        @(negedge clk);
        core_ack = 1'b1;
        @(negedge clk);
        core_ack = 1'b0;
    endtask

    task automatic set_pend(input int v, input bit on);
        if (v < 8) wr(on ? 3 : 4, 1 << v);
        else periph_req[v-8] = on;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; periph_req = '0; core_ack = 1'b0; wr_en = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_up();
    end

    initial begin
        int d;
        do_reset();

        // R1: reset state
        rd(0, d); check("R1 cur", d, 0);
        rd(5, d); check("R1 err", d, 0);
        rd(3, d); check("R1 sw", d, 0);
        for (int v = 0; v < NV; v++) begin rd(16 + v, d); check("R1 prio", d, 0); end
        check("R1 req", int'(irq_req), 0);

        // R11 / R2: software set and clear registers
        wr(3, 8'hA5); rd(3, d); check("R2 swset", d, 8'hA5);
        wr(4, 8'h81); rd(3, d); check("R2 swclr", d, 8'h24);

        // R2 R3: every vector alone at every priority
        for (int v = 0; v < NV; v++) begin
            for (int p = 0; p < 16; p++) begin
                do_reset();
                wr(16 + v, p);
                rd(16 + v, d); check("R2 prio readback", d, p);
                set_pend(v, 1'b1);
                idle(1);
                check("R3 req single", int'(irq_req), (p > 0) ? 1 : 0);
                if (p > 0) begin
                    check("R2 vector single", int'(irq_vector), v);
                    check("R3 prio single", int'(irq_prio), p);
                end
            end
        end

        // R9 R3: masking by the current priority
        do_reset();
        wr(16 + 9, 8);
        periph_req[1] = 1'b1;
        for (int c = 0; c < 16; c++) begin
            wr(0, c);
            rd(0, d); check("R9 cur readback", d, c);
            idle(1);
            check("R9 mask", int'(irq_req), (8 > c) ? 1 : 0);
        end

        // R4: every pair at equal priority, higher vector asserted first
        for (int a = 0; a < NV; a++) begin
            for (int b = a + 1; b < NV; b++) begin
                do_reset();
                wr(16 + a, 5); wr(16 + b, 5);
                set_pend(b, 1'b1);
                idle(1);
                set_pend(a, 1'b1);
                idle(1);
                check("R4 tie vector", int'(irq_vector), a);
            end
        end

        // R3 R4: full population, two arithmetic patterns, all current levels
        for (int pat = 0; pat < 2; pat++) begin
            do_reset();
            for (int v = 0; v < NV; v++)
                wr(16 + v, (pat == 0) ? ((v * 7 + 3) % 16) : ((v % 5) * 3));
            wr(3, 8'hFF);
            periph_req = '1;
            for (int c = 0; c < 16; c++) begin
                int bp, bv;
                bp = 0; bv = 0;
                for (int v = 0; v < NV; v++) begin
                    int p;
                    p = (pat == 0) ? ((v * 7 + 3) % 16) : ((v % 5) * 3);
                    if (p > c && p > bp) begin bp = p; bv = v; end
                end
                wr(0, c);
                idle(1);
                check("R3 pattern req", int'(irq_req), (bp > 0) ? 1 : 0);
                if (bp > 0) begin
                    check("R4 pattern vector", int'(irq_vector), bv);
                    check("R3 pattern prio", int'(irq_prio), bp);
                end
            end
        end

        // R5: acknowledge with nothing requested is ignored
        do_reset();
        ack();
        rd(0, d); check("R5 idle ack cur", d, 0);
        rd(1, d); check("R5 idle ack vec", d, 0);
        wr(2, 0);
        rd(5, d); check("R5 idle ack no push", d, 1);

        // R5 R6 R7 R4 R8: nested preempt and return
        do_reset();
        wr(16 + 8, 1); wr(16 + 12, 4); wr(16 + 11, 3); wr(16 + 10, 3);
        periph_req[0] = 1'b1; idle(1);
        check("R3 first req vec", int'(irq_vector), 8);
        ack();
        periph_req[0] = 1'b0;
        rd(0, d); check("R5 cur after ack", d, 1);
        rd(1, d); check("R5 ackvec", d, 8);
        check("R5 req drop", int'(irq_req), 0);
        periph_req[4] = 1'b1; idle(1);
        check("R3 preempt vec", int'(irq_vector), 12);
        ack(); periph_req[4] = 1'b0;
        rd(0, d); check("R5 cur level4", d, 4);
        periph_req[3] = 1'b1; idle(1);
        periph_req[2] = 1'b1; idle(1);
        check("R3 no preempt equal-lower", int'(irq_req), 0);
        wr(2, 0);
        rd(0, d); check("R7 restore 1", d, 1);
        idle(1);
        check("R4 later lower vector", int'(irq_vector), 10);
        ack(); periph_req[2] = 1'b0;
        rd(0, d); check("R5 cur level3", d, 3);
        idle(1);
        check("R3 same level masked", int'(irq_req), 0);
        wr(2, 0); idle(1);
        check("R7 next vec", int'(irq_vector), 11);
        ack(); periph_req[3] = 1'b0;
        wr(2, 0); rd(0, d); check("R7 back to 1", d, 1);
        wr(2, 0); rd(0, d); check("R7 back to 0", d, 0);
        rd(5, d); check("R8 no err yet", d, 0);
        wr(2, 0);
        rd(0, d); check("R8 cur kept", d, 0);
        rd(5, d); check("R8 err set", d, 1);
        wr(0, 2); rd(5, d); check("R8 sticky", d, 1);

        // R6: acknowledging a software vector clears its bit
        do_reset();
        wr(16 + 2, 6); wr(16 + 5, 2);
        wr(3, 8'h24); idle(1);
        check("R6 sw vec", int'(irq_vector), 2);
        ack();
        rd(3, d); check("R6 bit cleared", d, 8'h20);

        // R11: register write in the acknowledge cycle is dropped
        do_reset();
        wr(16 + 1, 7); wr(3, 2); idle(1);
        @(negedge clk);
        core_ack = 1'b1; wr_en = 1'b1; wr_addr = 6'h00; wr_data = 8'd12;
        @(negedge clk);
        core_ack = 1'b0; wr_en = 1'b0;
        rd(0, d); check("R11 ack wins", d, 7);

        // R10: seventeen saves into a 16-entry LIFO
        do_reset();
        wr(16, 1);
        for (int i = 0; i < 16; i++) begin
            wr(3, 1); idle(1); ack(); wr(0, 0);
        end
        rd(5, d); check("R10 full no err", d, 0);
        wr(3, 1); idle(1); ack();
        rd(0, d); check("R10 taken when full", d, 1);
        rd(5, d); check("R10 overflow err", d, 1);
        for (int i = 0; i < 16; i++) wr(2, 0);
        rd(0, d); check("R10 drained", d, 0);

        finish_up();
    end
endmodule